// File: doc/BRIEF.md
# CPU Address Window Decoder

This block takes a CPU physical address and decides which of eleven programmable address windows claims it. The windows are five per PCI port (one I/O window and four memory windows) plus one window that covers the chip's internal register block. For a claimed address the block reports a hit, the number of the enable bit that owns the window, and a target address. The target address is the offset into the window plus that window's 64-bit translation value.

Software programs the windows through a write-only port. Each window has a start field, a length field and a translation value. One shared enable word switches windows on and off, and a window is on when its bit is 0. By default, a write to a window's start field also loads bits 31:16 of its translation value. A configuration bit stops this copy. A lookup request is registered, and its result appears on the cycle after the request.

Top module: `cpu_win_decoder`

## Requirements
- R1: After reset every window is disabled and every lookup misses. `res_valid` is high exactly on the cycle after a cycle with `lk_valid` high.
- R2: The enable word is written at register address 0x30, and a 0 bit enables a window. The enable bits are:
  - bits 9, 10, 11, 12, 13: port 0's I/O window and memory windows 0–3 (slots 0–4);
  - bits 14 to 18: the same five windows on port 1 (slots 5–9);
  - bit 20: the internal window (slot 10).
  All other enable bits have no effect on decoding.
- R3: A window claims addresses `start <= a < start + len`. Here `start` is the base field shifted left by GRAN_W, and `len` is (size + 1) shifted left by GRAN_W.
- R4: On a hit, `res_addr` equals (address − start) + translation. The translation is {high word, low field, 16'h0000}, so the low field holds bits 31:16.
- R5: Window registers sit at address {slot[3:0], sub[1:0]}, with sub 0 = base, 1 = size, 2 = translation low, 3 = translation high. The configuration register is at 0x31, and its bit 27 is "no copy". While that bit is 0, a base write also stores data[15:0] into translation bits 31:16. While it is 1, a base write leaves the translation unchanged.
- R6: A base write keeps only data[BASE_W-1:0] as the start field, where BASE_W = ADDR_W − GRAN_W. A size write keeps only data[SIZE_W-1:0].
- R7: When windows overlap, the enabled window with the lowest enable bit number wins.
- R8: The internal window's base resets to the low BASE_W bits of INT_BASE_RST. Its length is fixed at one granule and its translation is fixed at 0, so writes to its size and translation registers have no effect.
- R9: A register write changes a lookup made on the following cycle or later. A lookup made in the same cycle as the write uses the values from before the write.
- R10: A write to the translation high register sets bits 63:32 and leaves bits 31:16 unchanged.
- R11: On a miss, `res_hit`, `res_idx` and `res_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 32 | Register write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | CPU address to decode |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_hit | output | 1 | A window claimed the address |
| res_idx | output | 5 | Enable bit number of the winning window |
| res_addr | output | 64 | Translated target address |

## Verification
The bench builds the block with ADDR_W=24, GRAN_W=12 and SIZE_W=4. With these values the address space has only 4096 granules, so every granule can be swept at its first and last byte, and every window edge can be hit exactly. The same sweep is repeated with each window enabled alone, and again for overlapping windows. These runs cover the priority order, the copy-on-base rule under both settings of the configuration bit, and a write and a lookup landing in the same cycle.

// File: rtl/cpu_win_pkg.sv
package cpu_win_pkg;
    localparam int NSLOT    = 11;
    localparam int INT_SLOT = 10;
    localparam int IDX_W    = 5;
    localparam int RA_W     = 6;
    localparam logic [RA_W-1:0] RA_ENABLE = 6'h30;
    localparam logic [RA_W-1:0] RA_CONFIG = 6'h31;
    localparam int NOCOPY_BIT = 27;
    localparam int RMLO_LSB   = 16;
    localparam int RMLO_W     = 16;

    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_SIZE = 2'd1,
        FLD_RMLO = 2'd2,
        FLD_RMHI = 2'd3
    } fld_e;

    // enable-word bit that owns a slot; also the reported window index
    function automatic logic [IDX_W-1:0] slot_bit(input int s);
        return (s == INT_SLOT) ? 5'd20 : 5'(s + 9);
    endfunction
endpackage

// File: rtl/cpu_win_regs.sv
module cpu_win_regs
    import cpu_win_pkg::*;
#(
    parameter int          BASE_W      = 20,
    parameter int          SIZE_W      = 16,
    parameter logic [31:0] INT_BASE_RST = 32'h0100_F100
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [RA_W-1:0]                wr_addr,
    input  logic [31:0]                    wr_data,
    output logic [NSLOT-1:0][BASE_W-1:0]   base_q,
    output logic [NSLOT-1:0][SIZE_W-1:0]   size_q,
    output logic [NSLOT-1:0][63:0]         remap_q,
    output logic [NSLOT-1:0]               off_q
);
    logic nocopy_q;
    fld_e fld;
    assign fld = fld_e'(wr_addr[1:0]);

    // shared enable word (only the decoded bits are kept) and copy control
    always_ff @(posedge clk) begin
        if (rst) begin
            off_q    <= '1;
            nocopy_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == RA_ENABLE) begin
                for (int s = 0; s < NSLOT; s++) begin
                    off_q[s] <= wr_data[slot_bit(s)];
                end
            end
            if (wr_addr == RA_CONFIG) begin
                nocopy_q <= wr_data[NOCOPY_BIT];
            end
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic sel;
        logic [BASE_W-1:0] b_q;
        assign sel       = wr_en && (wr_addr[RA_W-1:2] == 4'(s));
        assign base_q[s] = b_q;

        if (s == INT_SLOT) begin : g_int
            always_ff @(posedge clk) begin
                if (rst) begin
                    b_q <= INT_BASE_RST[BASE_W-1:0];
                end else if (sel && fld == FLD_BASE) begin
                    b_q <= wr_data[BASE_W-1:0];
                end
            end
            assign size_q[s]  = '0;
            assign remap_q[s] = '0;
        end else begin : g_pci
            logic [SIZE_W-1:0] sz_q;
            logic [RMLO_W-1:0] lo_q;
            logic [31:0]       hi_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    b_q  <= '0;
                    sz_q <= '0;
                    lo_q <= '0;
                    hi_q <= '0;
                end else if (sel) begin
                    unique case (fld)
                        FLD_BASE: begin
                            b_q <= wr_data[BASE_W-1:0];
                            if (!nocopy_q) lo_q <= wr_data[RMLO_W-1:0];
                        end
                        FLD_SIZE: sz_q <= wr_data[SIZE_W-1:0];
                        FLD_RMLO: lo_q <= wr_data[RMLO_W-1:0];
                        FLD_RMHI: hi_q <= wr_data;
                    endcase
                end
            end
            assign size_q[s]  = sz_q;
            assign remap_q[s] = {hi_q, lo_q, {RMLO_LSB{1'b0}}};
        end
    end
endmodule

// File: rtl/cpu_win_match.sv
module cpu_win_match
    import cpu_win_pkg::*;
#(
    parameter int ADDR_W = 36,
    parameter int GRAN_W = 16,
    parameter int SIZE_W = 16,
    localparam int BASE_W = ADDR_W - GRAN_W
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NSLOT-1:0][BASE_W-1:0]   base_q,
    input  logic [NSLOT-1:0][SIZE_W-1:0]   size_q,
    input  logic [NSLOT-1:0]               off_q,
    output logic [NSLOT-1:0]               hit_v,
    output logic [NSLOT-1:0][ADDR_W-1:0]   ofs
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] len;
        logic [ADDR_W:0]   diff;
        assign start  = {base_q[s], {GRAN_W{1'b0}}};
        assign len    = (ADDR_W'(size_q[s]) + ADDR_W'(1)) << GRAN_W;
        assign diff   = {1'b0, addr} - {1'b0, start};
        assign ofs[s] = diff[ADDR_W-1:0];
        assign hit_v[s] = !off_q[s] && !diff[ADDR_W] && (diff[ADDR_W-1:0] < len);
    end
endmodule

// File: rtl/cpu_win_pick.sv
module cpu_win_pick
    import cpu_win_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input  logic [NSLOT-1:0]               hit_v,
    input  logic [NSLOT-1:0][ADDR_W-1:0]   ofs,
    input  logic [NSLOT-1:0][63:0]         remap_q,
    output logic                           hit,
    output logic [IDX_W-1:0]               idx,
    output logic [63:0]                    tgt
);
    // scan from the top so the lowest slot (lowest enable bit) is left standing
    always_comb begin
        hit = 1'b0;
        idx = '0;
        tgt = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (hit_v[s]) begin
                hit = 1'b1;
                idx = slot_bit(s);
                tgt = 64'(ofs[s]) + remap_q[s];
            end
        end
    end
endmodule

// File: rtl/cpu_win_decoder.sv
module cpu_win_decoder
    import cpu_win_pkg::*;
#(
    parameter int          ADDR_W       = 36,
    parameter int          GRAN_W       = 16,
    parameter int          SIZE_W       = 16,
    parameter logic [31:0] INT_BASE_RST = 32'h0100_F100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [5:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [4:0]        res_idx,
    output logic [63:0]       res_addr
);
    localparam int BASE_W = ADDR_W - GRAN_W;

    logic [NSLOT-1:0][BASE_W-1:0] base_q;
    logic [NSLOT-1:0][SIZE_W-1:0] size_q;
    logic [NSLOT-1:0][63:0]       remap_q;
    logic [NSLOT-1:0]             off_q;
    logic [NSLOT-1:0]             hit_v;
    logic [NSLOT-1:0][ADDR_W-1:0] ofs;
    logic                         p_hit;
    logic [IDX_W-1:0]             p_idx;
    logic [63:0]                  p_tgt;

    cpu_win_regs #(
        .BASE_W(BASE_W), .SIZE_W(SIZE_W), .INT_BASE_RST(INT_BASE_RST)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .base_q(base_q), .size_q(size_q), .remap_q(remap_q), .off_q(off_q)
    );

    cpu_win_match #(
        .ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .SIZE_W(SIZE_W)
    ) u_match (
        .addr(lk_addr), .base_q(base_q), .size_q(size_q), .off_q(off_q),
        .hit_v(hit_v), .ofs(ofs)
    );

    cpu_win_pick #(.ADDR_W(ADDR_W)) u_pick (
        .hit_v(hit_v), .ofs(ofs), .remap_q(remap_q),
        .hit(p_hit), .idx(p_idx), .tgt(p_tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_idx   <= '0;
            res_addr  <= '0;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid && p_hit;
            res_idx   <= (lk_valid && p_hit) ? p_idx : '0;
            res_addr  <= (lk_valid && p_hit) ? p_tgt : '0;
        end
    end
endmodule

// File: rtl/cpu_win_decoder_chk.sv
module cpu_win_decoder_chk
    import cpu_win_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             res_valid,
    input logic             res_hit,
    input logic [4:0]       res_idx,
    input logic [63:0]      res_addr,
    input logic [NSLOT-1:0] hit_v
);
    function automatic logic [NSLOT-1:0] owner(input logic [4:0] i);
        return (i == 5'd20) ? NSLOT'(1) << INT_SLOT : NSLOT'(1) << (i - 5'd9);
    endfunction

    // R1: result follows a request by exactly one cycle
    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);
    a_r1_idle: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);
    // R11: a miss leaves index and address at zero
    a_r11_miss_clean: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_idx == 5'd0 && res_addr == 64'd0));
    // R2: only decoded enable positions are ever reported
    a_r2_idx_legal: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> ((res_idx >= 5'd9 && res_idx <= 5'd18) || res_idx == 5'd20));
    // R3: the registered hit agrees with the window comparators
    a_r3_hit_any: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_hit == $past(|hit_v)));
    // R7: the winner matched and no lower window matched
    a_r7_lowest: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> (($past(hit_v) & owner(res_idx)) != '0 &&
                     ($past(hit_v) & (owner(res_idx) - NSLOT'(1))) == '0));
endmodule

bind cpu_win_decoder cpu_win_decoder_chk u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .res_valid(res_valid),
    .res_hit(res_hit), .res_idx(res_idx), .res_addr(res_addr), .hit_v(hit_v)
);

// File: tb/cpu_win_decoder_test.sv
module cpu_win_decoder_test;
    localparam int AW = 24;
    localparam int GW = 12;
    localparam int SW = 4;
    localparam int BW = AW - GW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [5:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          res_valid, res_hit;
    logic [4:0]    res_idx;
    logic [63:0]   res_addr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench mirror of the programmed state, updated by the requirement rules
    logic [BW-1:0] m_base [11];
    logic [SW-1:0] m_size [11];
    logic [15:0]   m_lo   [11];
    logic [31:0]   m_hi   [11];
    logic [20:0]   m_en;
    logic          m_nocopy;

    cpu_win_decoder #(.ADDR_W(AW), .GRAN_W(GW), .SIZE_W(SW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
        .res_hit(res_hit), .res_idx(res_idx), .res_addr(res_addr)
    );

    always #10 clk = ~clk;

    function automatic int bit_of(input int s);
        return (s == 10) ? 20 : s + 9;
    endfunction

    function automatic void model(input logic [AW-1:0] a, output logic h,
                                  output logic [4:0] ix, output logic [63:0] t);
        h = 0; ix = 0; t = 0;
        for (int s = 0; s < 11; s++) begin
            longint st, ln;
            st = longint'(m_base[s]) * 4096;
            ln = (longint'(m_size[s]) + 1) * 4096;
            if (!h && !m_en[bit_of(s)] && longint'(a) >= st && longint'(a) < st + ln) begin
                h = 1;
                ix = 5'(bit_of(s));
                t = 64'(longint'(a) - st) + ((s == 10) ? 64'd0 : {m_hi[s], m_lo[s], 16'h0});
            end
        end
    endfunction

    task automatic mirror(input logic [5:0] ad, input logic [31:0] d);
        int s;
        s = int'(ad[5:2]);
        if (ad == 6'h30) m_en = d[20:0];
        else if (ad == 6'h31) m_nocopy = d[27];
        else if (s < 11) begin
            case (ad[1:0])
                2'd0: begin
                    m_base[s] = d[BW-1:0];
                    if (!m_nocopy && s != 10) m_lo[s] = d[15:0];
                end
                2'd1: if (s != 10) m_size[s] = d[SW-1:0];
                2'd2: if (s != 10) m_lo[s] = d[15:0];
                default: if (s != 10) m_hi[s] = d;
            endcase
        end
    endtask

    task automatic wr(input logic [5:0] ad, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = ad; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        mirror(ad, d);
    endtask

    task automatic compare(input string tag, input logic eh, input logic [4:0] ei,
                           input logic [63:0] et);
        checks++;
        if (res_valid !== 1'b1 || res_hit !== eh || res_idx !== ei || res_addr !== et) begin
            failures++;
            $display("FAIL %s: got v=%0b hit=%0b idx=%0d addr=%h exp hit=%0b idx=%0d addr=%h",
                     tag, res_valid, res_hit, res_idx, res_addr, eh, ei, et);
        end
    endtask

    task automatic look(input string tag, input logic [AW-1:0] a);
        logic eh; logic [4:0] ei; logic [63:0] et;
        model(a, eh, ei, et);
        @(negedge clk);
        lk_valid = 1; lk_addr = a;
        @(negedge clk);
        lk_valid = 0;
        compare(tag, eh, ei, et);
    endtask

    task automatic sweep(input string tag, input int p0, input int p1);
        for (int p = p0; p <= p1; p++) begin
            look(tag, AW'(p) << GW);
            look(tag, (AW'(p) << GW) | AW'(12'hFFF));
        end
    endtask

    // write and lookup in one cycle: the lookup must see the old state (R9)
    task automatic wr_and_look(input logic [5:0] ad, input logic [31:0] d,
                               input logic [AW-1:0] a);
        logic eh; logic [4:0] ei; logic [63:0] et;
        model(a, eh, ei, et);
        @(negedge clk);
        wr_en = 1; wr_addr = ad; wr_data = d; lk_valid = 1; lk_addr = a;
        @(negedge clk);
        wr_en = 0; lk_valid = 0;
        compare("R9 same-cycle old", eh, ei, et);
        mirror(ad, d);
        look("R9 next-cycle new", a);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 11; s++) begin
            m_base[s] = '0; m_size[s] = '0; m_lo[s] = '0; m_hi[s] = '0;
        end
        m_base[10] = 12'h100;
        m_en = '1;
        m_nocopy = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_hit !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: got v=%0b hit=%0b exp 0 0", res_valid, res_hit);
        end
        sweep("R1 all disabled after reset", 0, 4095);

        // program ten PCI windows; base writes copy into translation (R5)
        for (int s = 0; s < 10; s++) begin
            wr(6'((s << 2) | 0), 32'(12'h010 + s * 12'h020));
            wr(6'((s << 2) | 1), 32'hFFF0 | 32'(s));   // R6 upper size bits dropped
            if (s % 2 == 0) wr(6'((s << 2) | 2), 32'(16'hA000 + s));
        end
        wr(6'h07, 32'h1234_5678);                       // R10 slot 1 high word
        wr(6'h29, 32'h0000_0005);                       // R8 internal size ignored
        wr(6'h2A, 32'h0000_BEEF);                       // R8 internal remap ignored
        wr(6'h2B, 32'hDEAD_0000);

        // R2: only non-decoded bits cleared -> still nothing decodes
        wr(6'h30, 32'h001F_FFFF ^ 32'h0008_01FF);
        sweep("R2 non-decoded bits", 0, 383);

        wr(6'h30, 32'h0);
        sweep("R3 R4 R8 R10 all enabled", 0, 4095);

        for (int s = 0; s < 11; s++) begin
            wr(6'h30, 32'h001F_FFFF & ~(32'h1 << bit_of(s)));
            sweep("R2 single window", 0, 383);
        end

        // R6: bits above the base field are dropped
        wr(6'h30, 32'h0);
        wr(6'h10, 32'hFFFF_F123);
        sweep("R6 base mask", 12'h121, 12'h126);

        // R7: overlapping windows resolve to the lowest enable bit
        wr(6'h0C, 32'h300); wr(6'h0D, 32'h2);
        wr(6'h1C, 32'h301); wr(6'h1D, 32'h0);
        wr(6'h28, 32'h300);
        sweep("R7 overlap all on", 12'h2FF, 12'h303);
        wr(6'h30, 32'h0000_1000);
        sweep("R7 overlap bit12 off", 12'h2FF, 12'h303);
        wr(6'h30, 32'h0001_1000);
        sweep("R7 overlap bit16 off", 12'h2FF, 12'h303);

        // R5: copy blocked, then allowed again
        wr(6'h30, 32'h0);
        wr(6'h31, 32'h0800_0000);
        wr(6'h08, 32'h0000_0050);
        sweep("R5 copy blocked", 12'h050, 12'h053);
        wr(6'h31, 32'h0);
        wr(6'h08, 32'h0000_0051);
        sweep("R5 copy active", 12'h050, 12'h054);

        // R10: high word leaves bits 31:16 alone
        wr(6'h0B, 32'h0000_00C3);
        sweep("R10 high word", 12'h051, 12'h052);

        // R9: write and lookup in the same cycle
        wr_and_look(6'h00, 32'h0000_0700, 24'h700800);
        wr_and_look(6'h30, 32'h0000_0200, 24'h700800);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule